// File: doc/BRIEF.md
# Control-Character Action Unit

This unit watches every 8-bit line character moving in either direction and compares it with six programmable match codes. A character that hits one or more codes raises a set of one-cycle action strobes for the surrounding line controller. The controller then filters, synchronizes, interrupts, terminates or adjusts its check-character handling without help from the processor. Serial shifting, parity arithmetic and check-character arithmetic stay in the controller. This unit only decides which actions apply to the current character and to the one after it.

Each match code carries its own action mask. Some actions take effect on the character that matched. Others set a flag that covers only the next character on the line. The two termination codes are always recognized: they end the block and mark the following character as the check character. A command port lets software fire any action set directly.

Top module: `ctlchar_action_unit`

## Requirements
- R1: Entry e hits when bits 6..0 of the character equal its 7-bit code and its action mask is non-zero. Bit 7 of the character, the parity position, plays no part in recognition.
- R2: The action vector uses these bits: 0 filter, 1 achieve sync, 2 interrupt, 3 terminate, 4 inhibit recognition of next, 5 inhibit parity of next, 6 release channel, 7 exclude current from check, 8 exclude next from check, 9 next is check character. When several entries hit, the union of their masks is issued on `act_pulse` for exactly one cycle, in the cycle after the strobe.
- R3: The achieve-sync bit is honoured only for the lowest-numbered entry whose configured mask holds it. The same bit in any other entry's mask is dropped.
- R4: Bit 2 (interrupt) caused by a recognized character is dropped while `synced` is low.
- R5: Bit 0 (filter) caused by a recognized character is dropped when `chr_tx` is high, that is, in the transmit direction.
- R6: A character whose bits 6..0 are 0x03 or 0x17 always yields bits 3, 4, 5 and 9 (0x238), whatever the entries hold.
- R7: While `nxt_no_recog` is high at a strobe, that character yields no action from entries or from termination codes.
- R8: Each flag (`nxt_no_recog` from bit 4, `nxt_no_parity` from bit 5, `nxt_no_lrc` from bit 8, `nxt_is_lrc` from bit 9) rises in the cycle after an action carrying its bit. It stays high until the next character strobe and is then cleared, unless that same strobe sets it again.
- R9: `cmd_go` issues `cmd_act` with the same timing as a character, OR-ed with any character actions. Synchronization, direction and inhibit do not gate it, and it never clears a flag.
- R10: After reset, `act_pulse` and all four flags are zero.
- R11: In a cycle with neither a strobe nor `cmd_go`, the next cycle shows no action pulse and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_vld | input | 1 | One-cycle character strobe |
| chr_data | input | 8 | Line character, bit 7 is the parity position |
| chr_tx | input | 1 | 1 for transmit, 0 for receive |
| synced | input | 1 | Line synchronization achieved |
| ent_val | input | 42 | Six 7-bit match codes, entry e at bits 7e+6..7e |
| ent_act | input | 60 | Six 10-bit action masks, entry e at bits 10e+9..10e |
| cmd_go | input | 1 | Software action trigger |
| cmd_act | input | 10 | Actions fired by `cmd_go` |
| act_pulse | output | 10 | One-cycle action strobes |
| nxt_no_recog | output | 1 | Recognition inhibited for the next character |
| nxt_no_parity | output | 1 | Parity inhibited for the next character |
| nxt_no_lrc | output | 1 | Next character excluded from the check |
| nxt_is_lrc | output | 1 | Next character is the check character |

## Verification
The properties assume a strobe and a command in the same cycle are legal. For that reason, each gating property requires `cmd_go` to be low, so that software actions cannot hide a wrong character action. They also treat the configuration as free to change between strobes. The stimulus reloads the entry codes and masks every 150 strobes, drawing them from a pool that includes duplicate codes, several sync owners and the termination codes. Characters are picked mostly from the live codes, with random parity bits, so hits, unions and inhibited characters occur often.

// File: rtl/cca_pkg.sv
package cca_pkg;
    localparam int NACT = 10;

    localparam int A_FILTER    = 0;
    localparam int A_SYNC      = 1;
    localparam int A_INTR      = 2;
    localparam int A_TERM      = 3;
    localparam int A_INH_RECOG = 4;
    localparam int A_INH_PAR   = 5;
    localparam int A_RELEASE   = 6;
    localparam int A_LRC_CUR   = 7;
    localparam int A_LRC_EXCL  = 8;
    localparam int A_LRC_NEXT  = 9;

    // actions implied by a termination code
    localparam logic [NACT-1:0] TERM_BUNDLE = 10'b10_0011_1000;

    typedef struct packed {
        logic [NACT-1:0] pulse;
        logic            no_recog;
        logic            no_par;
        logic            no_lrc;
        logic            is_lrc;
    } cca_state_t;

    function automatic logic next_flag(input logic set, input logic clr, input logic cur);
        if (set)      return 1'b1;
        else if (clr) return 1'b0;
        else          return cur;
    endfunction
endpackage

// File: rtl/cca_entry_match.sv
module cca_entry_match
    import cca_pkg::*;
#(
    parameter int MW = 7
) (
    input  logic [MW-1:0]   chr,
    input  logic [MW-1:0]   val,
    input  logic [NACT-1:0] act,
    output logic            hit
);
    always_comb begin
        hit = (chr == val) && (|act);
    end
endmodule

// File: rtl/cca_mask_merge.sv
module cca_mask_merge
    import cca_pkg::*;
#(
    parameter int NENT = 6
) (
    input  logic [NENT*NACT-1:0] cfg_act,
    input  logic [NENT-1:0]      hit,
    output logic [NACT-1:0]      merged
);
    logic            owner_found;
    int              owner;
    logic [NACT-1:0] one_mask;

    always_comb begin
        owner_found = 1'b0;
        owner       = 0;
        for (int e = 0; e < NENT; e++) begin
            if (!owner_found && cfg_act[e*NACT + A_SYNC]) begin
                owner_found = 1'b1;
                owner       = e;
            end
        end
    end

    always_comb begin
        merged   = '0;
        one_mask = '0;
        for (int e = 0; e < NENT; e++) begin
            one_mask = cfg_act[e*NACT +: NACT];
            if (!(owner_found && owner == e)) begin
                one_mask[A_SYNC] = 1'b0;
            end
            if (hit[e]) begin
                merged = merged | one_mask;
            end
        end
    end
endmodule

// File: rtl/cca_term_detect.sv
module cca_term_detect #(
    parameter int MW     = 7,
    parameter int CODE_A = 3,
    parameter int CODE_B = 23
) (
    input  logic [MW-1:0] chr,
    output logic          is_term
);
    localparam logic [MW-1:0] CA = MW'(CODE_A);
    localparam logic [MW-1:0] CB = MW'(CODE_B);

    always_comb begin
        is_term = (chr == CA) || (chr == CB);
    end
endmodule

// File: rtl/ctlchar_action_unit.sv
module ctlchar_action_unit
    import cca_pkg::*;
#(
    parameter int NENT   = 6,
    parameter int CW     = 8,
    parameter int CODE_A = 3,
    parameter int CODE_B = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chr_vld,
    input  logic [CW-1:0]           chr_data,
    input  logic                    chr_tx,
    input  logic                    synced,
    input  logic [NENT*(CW-1)-1:0]  ent_val,
    input  logic [NENT*NACT-1:0]    ent_act,
    input  logic                    cmd_go,
    input  logic [NACT-1:0]         cmd_act,
    output logic [NACT-1:0]         act_pulse,
    output logic                    nxt_no_recog,
    output logic                    nxt_no_parity,
    output logic                    nxt_no_lrc,
    output logic                    nxt_is_lrc
);
    localparam int MW = CW - 1;

    logic [NENT-1:0] hit;
    logic [NACT-1:0] ent_merged;
    logic            is_term;
    logic [NACT-1:0] chr_act;
    logic [NACT-1:0] all_act;
    logic            unused_parity;
    cca_state_t      st_d, st_q;

    assign unused_parity = chr_data[CW-1];

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        cca_entry_match #(.MW(MW)) u_ent (
            .chr (chr_data[MW-1:0]),
            .val (ent_val[e*MW +: MW]),
            .act (ent_act[e*NACT +: NACT]),
            .hit (hit[e])
        );
    end

    cca_mask_merge #(.NENT(NENT)) u_merge (
        .cfg_act (ent_act),
        .hit     (hit),
        .merged  (ent_merged)
    );

    cca_term_detect #(.MW(MW), .CODE_A(CODE_A), .CODE_B(CODE_B)) u_term (
        .chr     (chr_data[MW-1:0]),
        .is_term (is_term)
    );

    always_comb begin
        chr_act = '0;
        if (chr_vld && !st_q.no_recog) begin
            chr_act = ent_merged;
            if (is_term) chr_act = chr_act | TERM_BUNDLE;
            if (!synced) chr_act[A_INTR]   = 1'b0;
            if (chr_tx)  chr_act[A_FILTER] = 1'b0;
        end
        all_act = chr_act | (cmd_go ? cmd_act : '0);

        st_d          = st_q;
        st_d.pulse    = all_act;
        st_d.no_recog = next_flag(all_act[A_INH_RECOG], chr_vld, st_q.no_recog);
        st_d.no_par   = next_flag(all_act[A_INH_PAR],   chr_vld, st_q.no_par);
        st_d.no_lrc   = next_flag(all_act[A_LRC_EXCL],  chr_vld, st_q.no_lrc);
        st_d.is_lrc   = next_flag(all_act[A_LRC_NEXT],  chr_vld, st_q.is_lrc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_pulse     = st_q.pulse;
    assign nxt_no_recog  = st_q.no_recog;
    assign nxt_no_parity = st_q.no_par;
    assign nxt_no_lrc    = st_q.no_lrc;
    assign nxt_is_lrc    = st_q.is_lrc;
endmodule

// File: rtl/cca_checker.sv
module cca_checker
    import cca_pkg::*;
#(
    parameter int MW = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            chr_vld,
    input logic [MW-1:0]   chr_low,
    input logic            chr_tx,
    input logic            synced,
    input logic            cmd_go,
    input logic [NACT-1:0] act_pulse,
    input logic            nxt_no_recog,
    input logic            nxt_no_parity,
    input logic            nxt_no_lrc,
    input logic            nxt_is_lrc
);
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (!chr_vld && !cmd_go) |=> (act_pulse == '0)); // R11
    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!chr_vld && !cmd_go) |=> $stable({nxt_no_recog, nxt_no_parity, nxt_no_lrc, nxt_is_lrc})); // R11
    AST_INTR_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (chr_vld && !synced && !cmd_go) |=> !act_pulse[A_INTR]); // R4
    AST_FILTER_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (chr_vld && chr_tx && !cmd_go) |=> !act_pulse[A_FILTER]); // R5
    AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (chr_vld && nxt_no_recog && !cmd_go) |=> (act_pulse == '0)); // R7
    AST_NEXT_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n) (chr_vld && nxt_no_recog && !cmd_go) |=> !(nxt_no_recog || nxt_no_parity || nxt_no_lrc || nxt_is_lrc)); // R8
    AST_TERM_BUNDLE: assert property (@(posedge clk) disable iff (!rst_n) (chr_vld && !nxt_no_recog && (chr_low == MW'(3) || chr_low == MW'(23))) |=> (act_pulse[A_TERM] && nxt_no_recog && nxt_no_parity && nxt_is_lrc)); // R6
endmodule

bind ctlchar_action_unit cca_checker #(.MW(CW-1)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chr_vld       (chr_vld),
    .chr_low       (chr_data[CW-2:0]),
    .chr_tx        (chr_tx),
    .synced        (synced),
    .cmd_go        (cmd_go),
    .act_pulse     (act_pulse),
    .nxt_no_recog  (nxt_no_recog),
    .nxt_no_parity (nxt_no_parity),
    .nxt_no_lrc    (nxt_no_lrc),
    .nxt_is_lrc    (nxt_is_lrc)
);

// File: tb/ctlchar_action_unit_tb.sv
module ctlchar_action_unit_tb;
    localparam int NE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chr_vld = 1'b0;
    logic [7:0]  chr_data = '0;
    logic        chr_tx = 1'b0;
    logic        synced = 1'b0;
    logic [41:0] ent_val;
    logic [59:0] ent_act;
    logic        cmd_go = 1'b0;
    logic [9:0]  cmd_act = '0;
    logic [9:0]  act_pulse;
    logic        nxt_no_recog, nxt_no_parity, nxt_no_lrc, nxt_is_lrc;

    logic [6:0]  cfg_val [NE];
    logic [9:0]  cfg_act [NE];
    logic [3:0]  m_fl = '0;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int e = 0; e < NE; e++) begin
            ent_val[e*7 +: 7]   = cfg_val[e];
            ent_act[e*10 +: 10] = cfg_act[e];
        end
    end

    ctlchar_action_unit u_dut (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
        .chr_tx(chr_tx), .synced(synced), .ent_val(ent_val), .ent_act(ent_act),
        .cmd_go(cmd_go), .cmd_act(cmd_act), .act_pulse(act_pulse),
        .nxt_no_recog(nxt_no_recog), .nxt_no_parity(nxt_no_parity),
        .nxt_no_lrc(nxt_no_lrc), .nxt_is_lrc(nxt_is_lrc)
    );

    function automatic logic [9:0] model_act(input logic v, input logic [7:0] d, input logic tx,
                                             input logic syn, input logic go, input logic [9:0] ca,
                                             input logic inhibited);
        logic [9:0] a = '0;
        int owner = -1;
        for (int e = 0; e < NE; e++)
            if (owner < 0 && cfg_act[e][1]) owner = e;
        if (v && !inhibited) begin
            for (int e = 0; e < NE; e++)
                if (cfg_act[e] != 0 && d[6:0] == cfg_val[e])
                    a = a | (cfg_act[e] & ((e == owner) ? 10'h3FF : 10'h3FD));
            if (d[6:0] == 7'h03 || d[6:0] == 7'h17) a = a | 10'h238;
            if (!syn) a[2] = 1'b0;
            if (tx)   a[0] = 1'b0;
        end
        if (go) a = a | ca;
        return a;
    endfunction

    function automatic logic [3:0] model_flags(input logic [9:0] a, input logic v, input logic [3:0] f);
        logic [3:0] n;
        n[3] = a[4] ? 1'b1 : (v ? 1'b0 : f[3]);
        n[2] = a[5] ? 1'b1 : (v ? 1'b0 : f[2]);
        n[1] = a[8] ? 1'b1 : (v ? 1'b0 : f[1]);
        n[0] = a[9] ? 1'b1 : (v ? 1'b0 : f[0]);
        return n;
    endfunction

    function automatic logic [3:0] flags_now();
        return {nxt_no_recog, nxt_no_parity, nxt_no_lrc, nxt_is_lrc};
    endfunction

    task automatic step(input logic v, input logic [7:0] d, input logic tx, input logic syn,
                        input logic go, input logic [9:0] ca, input string tag);
        logic [9:0] ea;
        logic [3:0] ef;
        @(negedge clk);
        chr_vld = v; chr_data = d; chr_tx = tx; synced = syn; cmd_go = go; cmd_act = ca;
        ea = model_act(v, d, tx, syn, go, ca, m_fl[3]);
        ef = model_flags(ea, v, m_fl);
        @(posedge clk);
        #1;
        checks++;
        if (act_pulse !== ea || flags_now() !== ef) begin
            errors++;
            $display("FAIL %s act=%h exp=%h flags=%b exp=%b", tag, act_pulse, ea, flags_now(), ef);
        end
        m_fl = ef;
        chr_vld = 1'b0; cmd_go = 1'b0;
    endtask

    task automatic lit(input logic [9:0] ea, input logic [3:0] ef, input string tag);
        checks++;
        if (act_pulse !== ea || flags_now() !== ef) begin
            errors++;
            $display("FAIL %s act=%h exp=%h flags=%b exp=%b", tag, act_pulse, ea, flags_now(), ef);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] pool [6];
        void'($urandom(32'h0C0FFEE5));
        pool[0] = 7'h16; pool[1] = 7'h02; pool[2] = 7'h03;
        pool[3] = 7'h17; pool[4] = 7'h05; pool[5] = 7'h10;

        cfg_val[0] = 7'h16; cfg_act[0] = 10'h003;
        cfg_val[1] = 7'h02; cfg_act[1] = 10'h005;
        cfg_val[2] = 7'h02; cfg_act[2] = 10'h0C0;
        cfg_val[3] = 7'h10; cfg_act[3] = 10'h130;
        cfg_val[4] = 7'h05; cfg_act[4] = 10'h006;
        cfg_val[5] = 7'h00; cfg_act[5] = 10'h000;

        repeat (3) @(posedge clk);
        #1;
        lit(10'h000, 4'b0000, "R10 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 8'h96, 0, 0, 0, '0, "R1 parity bit ignored");
        lit(10'h003, 4'b0000, "R1 code 16 with bit7 set");
        step(1, 8'h02, 0, 1, 0, '0, "R2 union");
        lit(10'h0C5, 4'b0000, "R2 union of two entries");
        step(1, 8'h02, 0, 0, 0, '0, "R4 unsynced");
        lit(10'h0C1, 4'b0000, "R4 interrupt dropped");
        step(1, 8'h82, 1, 1, 0, '0, "R5 transmit");
        lit(10'h0C4, 4'b0000, "R5 filter dropped on transmit");
        step(1, 8'h05, 0, 1, 0, '0, "R3 sync owner");
        lit(10'h004, 4'b0000, "R3 non-owner sync dropped");
        step(1, 8'h00, 0, 1, 0, '0, "R1 empty mask");
        lit(10'h000, 4'b0000, "R1 zero mask never hits");
        step(1, 8'h10, 0, 1, 0, '0, "R8 set flags");
        lit(10'h130, 4'b1110, "R8 next flags set");
        step(0, 8'h10, 0, 1, 0, '0, "R11 idle");
        lit(10'h000, 4'b1110, "R11 idle holds flags");
        step(1, 8'h02, 0, 1, 0, '0, "R7 inhibited");
        lit(10'h000, 4'b0000, "R7 R8 inhibited char silent, flags cleared");
        step(1, 8'h83, 0, 1, 0, '0, "R6 end of text");
        lit(10'h238, 4'b1101, "R6 termination bundle");
        step(1, 8'h16, 1, 0, 1, 10'h00C, "R9 command under inhibit");
        lit(10'h00C, 4'b0000, "R9 command ungated");
        step(0, 8'h00, 0, 0, 1, 10'h200, "R9 command alone");
        lit(10'h200, 4'b0001, "R9 command sets flag");
        step(0, 8'h00, 0, 0, 0, '0, "R11 idle after command");
        lit(10'h000, 4'b0001, "R11 no pulse, flag kept");
        step(1, 8'h17, 0, 1, 0, '0, "R6 end of block");
        lit(10'h238, 4'b1101, "R6 termination bundle second code");

        for (int i = 0; i < 1500; i++) begin
            logic [6:0] lo;
            int r;
            if (i % 150 == 0) begin
                for (int e = 0; e < NE; e++) begin
                    cfg_val[e] = ($urandom % 3 == 0) ? 7'($urandom) : pool[$urandom % 6];
                    cfg_act[e] = ($urandom % 4 == 0) ? 10'h000 : 10'($urandom);
                end
            end
            r = $urandom % 10;
            if (r < 6)      lo = cfg_val[$urandom % NE];
            else if (r < 8) lo = ($urandom % 2 == 1) ? 7'h03 : 7'h17;
            else            lo = 7'($urandom);
            step(($urandom % 8) != 0, {1'($urandom), lo}, 1'($urandom), 1'($urandom),
                 ($urandom % 6) == 0, 10'($urandom), "R2 R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule